// File: doc/BRIEF.md
# Masked Bit Test Condition Unit

This unit turns a data word and a bit mask into a 2-bit condition code. It serves two families of operations: a test form that reports whether the bits picked out by the mask are all clear, all set or mixed, and an insert form that reports whether the selected bits are all clear and, if not, the value of the most significant selected bit. Both forms run on either a 32-bit or a 64-bit operand.

The most significant set mask bit is located with a leading-zero count over the mask. The data word is then shifted left by that count, so the bit that decides the code lands in the top position. In the narrow modes the upper halves of data and mask are replaced by zeros before any of this. The code is registered, so it appears one clock after the inputs are presented. The unit does not move any bytes itself.

Top module: `mbt_cond_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `code_o` is 0.
- R2: When the data and mask have no set bit in common (this includes a zero mask), the code is 0 in every mode.
- R3: In a test mode (`mode_i[1]`=0), when every set mask bit has a set data bit under it, the code is 3.
- R4: In 64-bit test mode (`mode_i`=2'b01), a mixed selection gives 2 if the data bit under the highest set mask bit is 1, and 1 if it is 0.
- R5: In 32-bit test mode (`mode_i`=2'b00), a mixed selection always gives 1.
- R6: In an insert mode (`mode_i[1]`=1), a nonzero selection gives 1 when the data bit under the highest set mask bit is 1 and 2 when it is 0. An insert mode never gives 3.
- R7: In the 32-bit modes (`mode_i[0]`=0), bits 63..32 of `data_i` and `mask_i` have no effect on the code.
- R8: `mode_i[1]` selects insert (1) or test (0), and `mode_i[0]` selects 64-bit (1) or 32-bit (0). `code_o` reflects the inputs sampled at the previous rising clock edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bit 1: insert/test, bit 0: 64/32-bit |
| data_i | input | 64 | Data word |
| mask_i | input | 64 | Bit mask |
| code_o | output | 2 | Registered condition code |

## Verification
The bench sweeps all four modes over every pair of 4-bit mask and data nibbles. Each pair is placed at four bit positions: one low, two near the 32-bit boundary and one in the top byte. This exercises all-clear, all-set and mixed selections, and within the mixed case it tells a set leading bit from a clear one, so the 64-bit test codes can be told apart from the insert codes and from the fixed narrow-test answer. In the narrow modes, nonzero junk is driven into the upper halves of both inputs, and the top-byte placement must then read as an empty selection. Separate checks during reset, and between a mid-cycle input change and the next edge, establish the reset value and the one-cycle latency.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned HALF_W = 32;

    typedef enum logic [1:0] {
        MODE_TEST_N = 2'b00,
        MODE_TEST_W = 2'b01,
        MODE_INS_N  = 2'b10,
        MODE_INS_W  = 2'b11
    } mbt_mode_e;

    typedef enum logic [1:0] {
        CC_0 = 2'd0,
        CC_1 = 2'd1,
        CC_2 = 2'd2,
        CC_3 = 2'd3
    } mbt_cc_e;

    typedef struct packed {
        logic [1:0] code;
    } mbt_state_t;

endpackage

// File: rtl/mbt_lzc.sv
module mbt_lzc #(
    parameter int unsigned W     = 64,
    localparam int unsigned CNT_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);
    // Priority encoder: the highest set bit is visited last and wins.
    always_comb begin
        count_o = '0;
        zero_o  = 1'b1;
        for (int i = 0; i < int'(W); i++) begin
            if (vec_i[i]) begin
                count_o = CNT_W'(int'(W) - 1 - i);
                zero_o  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/mbt_lead_bit.sv
module mbt_lead_bit #(
    parameter int unsigned W     = 64,
    localparam int unsigned CNT_W = $clog2(W)
) (
    input  logic [W-1:0]     data_i,
    input  logic [CNT_W-1:0] shift_i,
    output logic             lead_o
);
    logic [W-1:0] shifted;

    always_comb begin
        shifted = data_i << shift_i;
        lead_o  = shifted[W-1];
    end
endmodule

// File: rtl/mbt_classify.sv
module mbt_classify
    import mbt_pkg::*;
(
    input  mbt_mode_e  mode_i,
    input  logic       mask_zero_i,
    input  logic       sel_zero_i,
    input  logic       sel_full_i,
    input  logic       lead_i,
    output logic [1:0] code_o
);
    logic insert, wide;

    always_comb begin
        insert = mode_i[1];
        wide   = mode_i[0];
        if (mask_zero_i || sel_zero_i) begin
            code_o = CC_0;
        end else if (!insert) begin
            if (sel_full_i) begin
                code_o = CC_3;
            end else if (wide) begin
                code_o = lead_i ? CC_2 : CC_1;
            end else begin
                code_o = CC_1;
            end
        end else begin
            code_o = lead_i ? CC_1 : CC_2;
        end
    end
endmodule

// File: rtl/mbt_cond_unit.sv
module mbt_cond_unit
    import mbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [WORD_W-1:0] mask_i,
    output logic [1:0]        code_o
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam int unsigned HI_W  = WORD_W - HALF_W;

    mbt_mode_e         mode;
    logic [WORD_W-1:0] data_eff, mask_eff, sel;
    logic [CNT_W-1:0]  lz_count;
    logic              mask_zero, lead, sel_zero, sel_full;
    logic [1:0]        code_c;
    mbt_state_t        state_d, state_q;

    // Narrow modes see only the low half of each operand.
    always_comb begin
        mode = mbt_mode_e'(mode_i);
        if (mode_i[0]) begin
            data_eff = data_i;
            mask_eff = mask_i;
        end else begin
            data_eff = {{HI_W{1'b0}}, data_i[HALF_W-1:0]};
            mask_eff = {{HI_W{1'b0}}, mask_i[HALF_W-1:0]};
        end
        sel      = data_eff & mask_eff;
        sel_zero = (sel == '0);
        sel_full = (sel == mask_eff);
    end

    mbt_lzc #(.W(WORD_W)) u_lzc (
        .vec_i   (mask_eff),
        .count_o (lz_count),
        .zero_o  (mask_zero)
    );

    mbt_lead_bit #(.W(WORD_W)) u_lead (
        .data_i  (data_eff),
        .shift_i (lz_count),
        .lead_o  (lead)
    );

    mbt_classify u_cls (
        .mode_i      (mode),
        .mask_zero_i (mask_zero),
        .sel_zero_i  (sel_zero),
        .sel_full_i  (sel_full),
        .lead_i      (lead),
        .code_o      (code_c)
    );

    always_comb begin
        state_d      = state_q;
        state_d.code = code_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign code_o = state_q.code;
endmodule

// File: rtl/mbt_cond_unit_chk.sv
module mbt_cond_unit_chk
    import mbt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [WORD_W-1:0] data_i,
    input logic [WORD_W-1:0] mask_i,
    input logic [1:0]        code_o
);
    logic [WORD_W-1:0] d_v, m_v;

    always_comb begin
        d_v = mode_i[0] ? data_i : {{(WORD_W-HALF_W){1'b0}}, data_i[HALF_W-1:0]};
        m_v = mode_i[0] ? mask_i : {{(WORD_W-HALF_W){1'b0}}, mask_i[HALF_W-1:0]};
    end

    p_empty_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((d_v & m_v) == '0)) |-> (code_o == 2'd0));

    p_full_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!mode_i[1] && m_v != '0 && (d_v & m_v) == m_v))
            |-> (code_o == 2'd3));

    p_narrow_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i == 2'b00)) |-> (code_o != 2'd2));

    p_insert_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i[1])) |-> (code_o != 2'd3));

    p_upper_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!mode_i[0] && m_v == '0)) |-> (code_o == 2'd0));
endmodule

bind mbt_cond_unit mbt_cond_unit_chk u_chk (.*);

// File: tb/mbt_cond_unit_bench.sv
module mbt_cond_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [63:0] data_i = '0;
    logic [63:0] mask_i = '0;
    logic [1:0]  code_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mbt_cond_unit u_mbt_cond_unit (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .data_i (data_i),
        .mask_i (mask_i),
        .code_o (code_o)
    );

    function automatic logic [1:0] ref_code(input logic [1:0] mo,
                                            input logic [63:0] d,
                                            input logic [63:0] m);
        logic [63:0] de, me;
        int top;
        de = mo[0] ? d : {32'h0, d[31:0]};
        me = mo[0] ? m : {32'h0, m[31:0]};
        if ((de & me) == 64'h0) return 2'd0;
        top = 0;
        for (int i = 0; i < 64; i++) if (me[i]) top = i;
        if (!mo[1]) begin
            if ((de & me) == me) return 2'd3;
            if (!mo[0]) return 2'd1;
            return de[top] ? 2'd2 : 2'd1;
        end
        return de[top] ? 2'd1 : 2'd2;
    endfunction

    function automatic string req_of(input logic [1:0] mo,
                                     input logic [63:0] d,
                                     input logic [63:0] m);
        logic [63:0] de, me;
        string r;
        de = mo[0] ? d : {32'h0, d[31:0]};
        me = mo[0] ? m : {32'h0, m[31:0]};
        if ((de & me) == 64'h0) r = "R2";
        else if (!mo[1] && (de & me) == me) r = "R3";
        else if (mo == 2'b01) r = "R4";
        else if (mo == 2'b00) r = "R5";
        else r = "R6";
        if (!mo[0]) r = {r, " R7"};
        return r;
    endfunction

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (code_o !== exp) begin
            errors++;
            $display("FAIL %s mode=%b data=%h mask=%h actual=%0d expected=%0d",
                     req, mode_i, data_i, mask_i, code_o, exp);
        end
    endtask

    task automatic apply(input logic [1:0] mo, input logic [63:0] d, input logic [63:0] m);
        @(negedge clk);
        mode_i = mo;
        data_i = d;
        mask_i = m;
        @(posedge clk);
        #1;
        check(req_of(mo, d, m), ref_code(mo, d, m));
    endtask

    initial begin
        // R1: reset value, even with inputs that would give code 3
        mode_i = 2'b01;
        data_i = '1;
        mask_i = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 2'd0);

        // R8: one-cycle latency and hold between edges
        apply(2'b01, 64'h8000_0000_0000_0000, 64'hC000_0000_0000_0000);
        @(negedge clk);
        mode_i = 2'b11;
        data_i = 64'h0;
        mask_i = 64'h1;
        #1;
        check("R8", 2'd2);
        @(posedge clk);
        #1;
        check("R8", 2'd0);

        // Directed corners
        apply(2'b11, 64'h0, 64'h0);                             // R2 zero mask
        apply(2'b00, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000); // R7
        apply(2'b01, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001); // R3
        apply(2'b10, 64'h0000_0000_4000_0000, 64'h0000_0000_C000_0000); // R6
        apply(2'b01, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001); // R4

        // Sweep: modes x nibble positions x mask x data
        for (int mo = 0; mo < 4; mo++) begin
            for (int pi = 0; pi < 4; pi++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int d = 0; d < 16; d++) begin
                        int pos;
                        logic [63:0] dv, mv;
                        case (pi)
                            0: pos = 0;
                            1: pos = 28;
                            2: pos = 30;
                            default: pos = 60;
                        endcase
                        dv = 64'(d) << pos;
                        mv = 64'(m) << pos;
                        if (mo[0] == 0) begin
                            dv = dv | ({32'(32'hA5C3_0000 ^ (m * 16 + d)), 32'h0});
                            mv = mv | ({32'(32'h5A3C_0001 ^ (d * 16 + m)), 32'h0});
                        end
                        apply(2'(mo), dv, mv);
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule